// File: doc/BRIEF.md
# Serial Peripheral Low-Power Mode Controller

This block sits beside a serial peripheral's shift engine and decides when that peripheral may drop into one of two low-power modes. A system-level stop request is acknowledged at once. Readiness for clock removal is reported only once the serial frame in flight has finished. A software module-disable bit drops a clock-enable output, again only at a frame boundary. Clearing either request returns the peripheral to normal running on the next clock.

While the peripheral is not in its normal running state, the block blocks the FIFO push, pop and clear strobes. While it is disabled, writes to the two FIFO-disable configuration bits are dropped. The register interface therefore keeps answering accesses, but they change nothing. While stopped, the interrupt and DMA request outputs are frozen at the values they had when the stop took effect.

A frame boundary is any cycle in which the frame-busy input is low or a frame-end pulse is present.

Top module: `spi_lp_mode_ctrl`

## Requirements
- R1: After reset, stop_ready_o and stop_ack_o are 0, clk_en_o is 1, and txf_dis_o and rxf_dis_o are 0.
- R2: If stop_req_i is high in the running state on a frame boundary, stop_ack_o and stop_ready_o are both 1 after the next clock.
- R3: If stop_req_i is high while a frame is active, stop_ack_o goes to 1 after the next clock. stop_ready_o stays 0 until the clock edge on which a frame boundary is sampled, and is 1 after that edge.
- R4: While stop_ready_o is 1, irq_o and dma_o hold the irq_i and dma_i values sampled on the clock edge that entered the stopped state. At all other times they follow irq_i and dma_i combinationally.
- R5: If stop_req_i is low on a clock edge, stop_ack_o and stop_ready_o are 0 after that edge, and the block is back in the running state.
- R6: If mdis_i is high (and stop_req_i low) in the running state, clk_en_o falls after the first clock edge that samples a frame boundary. It stays 1 through edges that sample an active frame.
- R7: If mdis_i is low on a clock edge, clk_en_o is 1 after that edge.
- R8: tx_push_o, rx_pop_o, tx_clr_o and rx_clr_o equal their input strobes only in the running state, that is when stop_ack_o is 0 and clk_en_o is 1 with no disable pending. In every other state they are 0.
- R9: A cfg_wr_i pulse loads cfg_txdis_i into txf_dis_o and cfg_rxdis_i into rxf_dis_o on the next clock, unless clk_en_o is 0. In that case both bits are unchanged.
- R10: stop_req_i takes priority over mdis_i in the running and disable-pending states. While disabled, stop_req_i is ignored: stop_ack_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req_i | input | 1 | System stop request |
| mdis_i | input | 1 | Module-disable configuration bit |
| frame_busy_i | input | 1 | Serial frame in progress |
| frame_end_i | input | 1 | Pulse on the last cycle of a frame |
| irq_i | input | IRQ_W | Live interrupt requests |
| dma_i | input | DMA_W | Live DMA requests |
| tx_push_i | input | 1 | Transmit FIFO push strobe |
| rx_pop_i | input | 1 | Receive FIFO pop strobe |
| tx_clr_i | input | 1 | Transmit FIFO clear strobe |
| rx_clr_i | input | 1 | Receive FIFO clear strobe |
| cfg_wr_i | input | 1 | Write strobe for the FIFO-disable bits |
| cfg_txdis_i | input | 1 | Write data, transmit FIFO disable |
| cfg_rxdis_i | input | 1 | Write data, receive FIFO disable |
| stop_ack_o | output | 1 | Stop request acknowledged |
| stop_ready_o | output | 1 | Clocks may be removed |
| clk_en_o | output | 1 | Clock enable for non-register logic |
| irq_o | output | IRQ_W | Interrupt requests, frozen while stopped |
| dma_o | output | DMA_W | DMA requests, frozen while stopped |
| tx_push_o | output | 1 | Gated push strobe |
| rx_pop_o | output | 1 | Gated pop strobe |
| tx_clr_o | output | 1 | Gated transmit clear |
| rx_clr_o | output | 1 | Gated receive clear |
| txf_dis_o | output | 1 | Transmit FIFO disable bit |
| rxf_dis_o | output | 1 | Receive FIFO disable bit |

## Verification
The bench targets requests that arrive in the same cycle as a frame-end pulse. A design that ignored the pulse would stall one frame too long. It also targets frames that stay busy across many edges, where a design that entered a mode early would cut a frame short. Disable-pending states that are overtaken by a stop request check the priority rule: getting it wrong leaves clk_en_o low while stopped. Configuration writes issued while disabled check the write blocking: a design that let them through would silently change the FIFO-disable bits. Interrupt inputs that toggle during a stop show whether the outputs are truly frozen at the entry value or leak the live inputs.

// File: rtl/spi_lp_mode_ctrl.sv
module spi_lp_mode_ctrl #(
  parameter int IRQ_W = 4,
  parameter int DMA_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req_i,
  input  logic             mdis_i,
  input  logic             frame_busy_i,
  input  logic             frame_end_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [DMA_W-1:0] dma_i,
  input  logic             tx_push_i,
  input  logic             rx_pop_i,
  input  logic             tx_clr_i,
  input  logic             rx_clr_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_txdis_i,
  input  logic             cfg_rxdis_i,
  output logic             stop_ack_o,
  output logic             stop_ready_o,
  output logic             clk_en_o,
  output logic [IRQ_W-1:0] irq_o,
  output logic [DMA_W-1:0] dma_o,
  output logic             tx_push_o,
  output logic             rx_pop_o,
  output logic             tx_clr_o,
  output logic             rx_clr_o,
  output logic             txf_dis_o,
  output logic             rxf_dis_o
);

  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_PSTOP = 3'd1,
    M_STOP  = 3'd2,
    M_PDIS  = 3'd3,
    M_DIS   = 3'd4
  } mode_t;

  mode_t mode_q, mode_d;
  logic [IRQ_W-1:0] irq_hold_q;
  logic [DMA_W-1:0] dma_hold_q;

  wire boundary = !frame_busy_i || frame_end_i;
  wire running  = (mode_q == M_RUN);
  wire stopped  = (mode_q == M_STOP);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_RUN, M_PDIS: begin
        if (stop_req_i)
          mode_d = boundary ? M_STOP : M_PSTOP;
        else if (mdis_i)
          mode_d = boundary ? M_DIS : M_PDIS;
        else
          mode_d = M_RUN;
      end
      M_PSTOP: begin
        if (!stop_req_i)   mode_d = M_RUN;
        else if (boundary) mode_d = M_STOP;
      end
      M_STOP: if (!stop_req_i) mode_d = M_RUN;
      M_DIS:  if (!mdis_i)     mode_d = M_RUN;
      default: mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_RUN;
      irq_hold_q <= '0;
      dma_hold_q <= '0;
      txf_dis_o  <= 1'b0;
      rxf_dis_o  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (!stopped) begin
        irq_hold_q <= irq_i;
        dma_hold_q <= dma_i;
      end
      if (cfg_wr_i && mode_q != M_DIS) begin
        txf_dis_o <= cfg_txdis_i;
        rxf_dis_o <= cfg_rxdis_i;
      end
    end
  end

  assign stop_ack_o   = (mode_q == M_PSTOP) || stopped;
  assign stop_ready_o = stopped;
  assign clk_en_o     = (mode_q != M_DIS);

  assign irq_o = stopped ? irq_hold_q : irq_i;
  assign dma_o = stopped ? dma_hold_q : dma_i;

  assign tx_push_o = tx_push_i && running;
  assign rx_pop_o  = rx_pop_i  && running;
  assign tx_clr_o  = tx_clr_i  && running;
  assign rx_clr_o  = rx_clr_i  && running;

endmodule

// File: rtl/spi_lp_mode_ctrl_chk.sv
module spi_lp_mode_ctrl_chk #(
  parameter int IRQ_W = 4,
  parameter int DMA_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req_i,
  input logic             mdis_i,
  input logic             frame_busy_i,
  input logic             frame_end_i,
  input logic             cfg_wr_i,
  input logic             tx_push_i,
  input logic             stop_ack_o,
  input logic             stop_ready_o,
  input logic             clk_en_o,
  input logic [IRQ_W-1:0] irq_o,
  input logic [DMA_W-1:0] dma_o,
  input logic             tx_push_o,
  input logic             rx_pop_o,
  input logic             tx_clr_o,
  input logic             rx_clr_o,
  input logic             txf_dis_o,
  input logic             rxf_dis_o
);

  assert_idle_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req_i && clk_en_o && (!frame_busy_i || frame_end_i)) |=> stop_ready_o);

  assert_wait_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_ready_o && frame_busy_i && !frame_end_i) |=> !stop_ready_o);

  assert_freeze_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ready_o && $past(stop_ready_o)) |-> ($stable(irq_o) && $stable(dma_o)));

  assert_release_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_req_i |=> (!stop_ready_o && !stop_ack_o));

  assert_defer_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o && frame_busy_i && !frame_end_i) |=> clk_en_o);

  assert_reenable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mdis_i |=> clk_en_o);

  assert_gate_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ack_o || !clk_en_o) |-> !(tx_push_o || rx_pop_o || tx_clr_o || rx_clr_o));

  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o |=> ($stable(txf_dis_o) && $stable(rxf_dis_o)));

  assert_no_ack_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_o && mdis_i) |=> !stop_ack_o);

endmodule

bind spi_lp_mode_ctrl spi_lp_mode_ctrl_chk #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .stop_req_i(stop_req_i), .mdis_i(mdis_i),
  .frame_busy_i(frame_busy_i), .frame_end_i(frame_end_i), .cfg_wr_i(cfg_wr_i),
  .tx_push_i(tx_push_i), .stop_ack_o(stop_ack_o), .stop_ready_o(stop_ready_o),
  .clk_en_o(clk_en_o), .irq_o(irq_o), .dma_o(dma_o), .tx_push_o(tx_push_o),
  .rx_pop_o(rx_pop_o), .tx_clr_o(tx_clr_o), .rx_clr_o(rx_clr_o),
  .txf_dis_o(txf_dis_o), .rxf_dis_o(rxf_dis_o)
);

// File: tb/spi_lp_mode_ctrl_tb_top.sv
module spi_lp_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IRQ_W = 4;
  localparam int DMA_W = 2;

  logic clk = 0, rst_n = 0;
  logic stop_req, mdis, busy, fend, cfg_wr, cfg_tx, cfg_rx;
  logic push, pop, tclr, rclr;
  logic [IRQ_W-1:0] irq_in;
  logic [DMA_W-1:0] dma_in;
  logic ack, ready, cen, push_o, pop_o, tclr_o, rclr_o, txd, rxd;
  logic [IRQ_W-1:0] irq_out;
  logic [DMA_W-1:0] dma_out;

  int vectors = 0, errors = 0;
  bit done = 0;

  // model: 0 run, 1 pending stop, 2 stopped, 3 pending disable, 4 disabled
  int m_st;
  logic [IRQ_W-1:0] m_irq;
  logic [DMA_W-1:0] m_dma;
  logic m_txd, m_rxd;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_lp_mode_ctrl #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req_i(stop_req), .mdis_i(mdis),
    .frame_busy_i(busy), .frame_end_i(fend), .irq_i(irq_in), .dma_i(dma_in),
    .tx_push_i(push), .rx_pop_i(pop), .tx_clr_i(tclr), .rx_clr_i(rclr),
    .cfg_wr_i(cfg_wr), .cfg_txdis_i(cfg_tx), .cfg_rxdis_i(cfg_rx),
    .stop_ack_o(ack), .stop_ready_o(ready), .clk_en_o(cen),
    .irq_o(irq_out), .dma_o(dma_out), .tx_push_o(push_o), .rx_pop_o(pop_o),
    .tx_clr_o(tclr_o), .rx_clr_o(rclr_o), .txf_dis_o(txd), .rxf_dis_o(rxd)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_state(int s);
    bit b = !busy || fend;
    case (s)
      0, 3: return stop_req ? (b ? 2 : 1) : (mdis ? (b ? 4 : 3) : 0);
      1: return !stop_req ? 0 : (b ? 2 : 1);
      2: return stop_req ? 2 : 0;
      default: return mdis ? 4 : 0;
    endcase
  endfunction

  task automatic compare();
    logic run = (m_st == 0);
    check({7'd0, ack}, {7'd0, (m_st == 1 || m_st == 2)}, "R2/R3 ack");
    check({7'd0, ready}, {7'd0, (m_st == 2)}, "R3/R5 ready");
    check({7'd0, cen}, {7'd0, (m_st != 4)}, "R6/R7 clk_en");
    check({4'd0, push_o, pop_o, tclr_o, rclr_o},
          {4'd0, push & run, pop & run, tclr & run, rclr & run}, "R8 strobes");
    check({2'd0, irq_out, dma_out},
          {2'd0, (m_st == 2) ? m_irq : irq_in, (m_st == 2) ? m_dma : dma_in}, "R4 freeze");
    check({6'd0, txd, rxd}, {6'd0, m_txd, m_rxd}, "R9 cfg");
  endtask

  task automatic step(input logic sr, input logic md, input logic bz, input logic fe,
                      input logic wr, input logic [1:0] wd);
    stop_req = sr; mdis = md; busy = bz; fend = fe; cfg_wr = wr;
    cfg_tx = wd[1]; cfg_rx = wd[0];
    irq_in = IRQ_W'($urandom); dma_in = DMA_W'($urandom);
    {push, pop, tclr, rclr} = 4'($urandom);
    #1 compare();
    @(posedge clk);
    if (m_st != 2) begin m_irq = irq_in; m_dma = dma_in; end
    if (wr && m_st != 4) begin m_txd = wd[1]; m_rxd = wd[0]; end
    m_st = next_state(m_st);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1d5e_2a07));
    {stop_req, mdis, busy, fend, cfg_wr, cfg_tx, cfg_rx, push, pop, tclr, rclr} = '0;
    irq_in = '0; dma_in = '0;
    m_st = 0; m_irq = '0; m_dma = '0; m_txd = 0; m_rxd = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({4'd0, ack, ready, cen, txd | rxd}, 8'b0000_0010, "R1 reset");
    rst_n = 1;
    @(negedge clk);
    // R2 idle stop, R5 release
    step(1, 0, 0, 0, 0, 0); step(1, 0, 1, 0, 0, 0); step(1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
    // R3 frame active, end pulse with busy still high
    step(1, 0, 1, 0, 0, 0); step(1, 0, 1, 0, 0, 0); step(1, 0, 1, 1, 0, 0);
    step(1, 0, 1, 0, 0, 0); step(0, 0, 1, 0, 0, 0);
    // R6 deferred disable, R9 write blocked, R7 re-enable
    step(0, 1, 1, 0, 1, 2'b11); step(0, 1, 1, 0, 0, 0); step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 1, 2'b00); step(0, 1, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 2'b01); step(0, 0, 0, 0, 0, 0);
    // R10 stop overtakes pending disable; stop ignored when disabled
    step(0, 1, 1, 0, 0, 0); step(1, 1, 1, 1, 0, 0); step(1, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic sr = (i % 97) < 40 ? ($urandom_range(0, 15) != 0) : ($urandom_range(0, 15) == 0);
      logic md = (i % 131) > 60 ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 9) == 0);
      step(sr, md, $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 3) == 0, 2'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule